// File: doc/BRIEF.md
# Serial Byte Receiver with Drift Resynchronisation

This block turns an asynchronous serial line into bytes for a small soft processor. Each frame has one start bit, eight data bits sent least significant bit first, and one stop bit. There is no parity. The bit period is a whole number of system clocks, set by a parameter. The line passes through a two-flop synchroniser. A falling edge on the idle-high line starts a frame. The start bit is checked again at its midpoint, and each data bit is sampled at its midpoint.

The stop bit is only sampled at its midpoint, which is half a bit period into the stop phase. The receiver then returns to idle, so the rest of the stop bit gives time to accept the byte and wait for the next start bit. A sender whose clock runs slightly fast may begin the next start bit before that midpoint. A falling edge during the stop phase therefore delivers the current byte and starts the next frame at once.

The processor side is a combinational read port with two selectable words, data and status, and several read widths. A halfword read of the data word returns all ones when no byte is waiting. This keeps "empty" distinct from a received zero byte. One holding register keeps the most recent byte. A sticky flag records that a byte was overwritten before it was read.

Top module: `srx_port`

## Requirements
- R1: A frame with a low start bit, eight data bits (first bit on the line is bit 0) and a high stop bit makes the received byte readable, with the valid flag set.
- R2: A halfword data read (`rd_sel`=0, `rd_kind`=2 or 3) returns 0xFFFFFFFF when no byte is waiting. When a byte is waiting it returns 0x000000XX, where XX is the byte, and a 0x00 byte gives 0x00000000.
- R3: A byte data read with `rd_kind`=0 returns the low 8 bits of the halfword value, zero-extended. With `rd_kind`=1 it returns the same 8 bits sign-extended. When empty, these reads give 0x000000FF and 0xFFFFFFFF.
- R4: A data read with `rd_en` high clears the valid flag at the clock edge that ends the read cycle. A status read does not clear it.
- R5: A status read (`rd_sel`=1) returns valid in bit 0 and overrun in bit 1, with all other bits zero. Such a read with `rd_en` high clears the overrun flag.
- R6: When a byte completes while a byte is still waiting and is not being read in that cycle, the overrun flag is set. The holding register keeps the newer byte.
- R7: A low pulse shorter than half a bit period is rejected at the start-bit midpoint, and no byte is produced.
- R8: If the stop bit is sampled low at its midpoint and no falling edge was seen during the stop phase, the byte is discarded.
- R9: A falling edge during the stop phase, before the stop midpoint, delivers the current byte and is taken as the start bit of the next frame. Both bytes are received correctly.
- R10: After reset no byte is waiting and the overrun flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| rd_en | input | 1 | Read strobe; enables the read side effects |
| rd_sel | input | 1 | 0 selects the data word, 1 selects the status word |
| rd_kind | input | 2 | 0 unsigned byte, 1 signed byte, 2 or 3 halfword |
| rd_data | output | 32 | Combinational read value for the current selection |

## Verification
The bench sends every byte value from 0x00 to 0xFF and rotates through the three read widths, so it covers bit-order mistakes and extension mistakes. It also checks that a zero byte reads back differently from an empty receiver. Four corner cases are driven separately:
- **Start glitch:** a short low pulse. A receiver that skips the start-bit midpoint check would produce a phantom 0xFF byte.
- **Framing error:** a zero byte with a low stop bit. A receiver that ignores the stop sample would report that byte.
- **Early start bit:** a frame whose stop bit is cut to three clocks. A receiver that waits out the full stop bit would drop the first byte or mis-align the second.
- **Overrun:** two frames with no read in between. The bench checks that the overrun flag is set, that it clears on a status read, and that the newer byte is the one kept.

// File: rtl/srx_pkg.sv
package srx_pkg;

  parameter int unsigned DATA_W = 8;
  parameter int unsigned WORD_W = 32;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;

  parameter logic [1:0] KIND_BYTE_U = 2'd0;
  parameter logic [1:0] KIND_BYTE_S = 2'd1;

  parameter logic SEL_DATA   = 1'b0;
  parameter logic SEL_STATUS = 1'b1;

endpackage

// File: rtl/srx_sync.sv
// Multi-stage synchroniser; also used as a reset release synchroniser.
module srx_sync #(
  parameter int unsigned Stages   = 2,
  parameter logic        ResetVal = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);

  logic [Stages-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {Stages{ResetVal}};
    end else begin
      chain_q <= {chain_q[Stages-2:0], d_in};
    end
  end

  assign d_out = chain_q[Stages-1];

endmodule

// File: rtl/srx_framer.sv
// Bit timing and frame state machine.
module srx_framer
  import srx_pkg::*;
#(
  parameter int unsigned ClksPerBit = 174,
  parameter int unsigned DataBits   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_sync,
  output logic                byte_done,
  output logic [DataBits-1:0] byte_out
);

  localparam int unsigned CntW    = (ClksPerBit > 2) ? $clog2(ClksPerBit) : 1;
  localparam int unsigned BitW    = $clog2(DataBits + 1);
  localparam int unsigned HalfBit = ClksPerBit / 2;
  localparam logic [CntW-1:0] HalfLast = CntW'(HalfBit - 1);
  localparam logic [CntW-1:0] FullLast = CntW'(ClksPerBit - 1);
  localparam logic [BitW-1:0] BitLast  = BitW'(DataBits - 1);

  rx_state_e           state_q, state_d;
  logic [CntW-1:0]     cnt_q, cnt_d;
  logic [BitW-1:0]     bits_q, bits_d;
  logic [DataBits-1:0] shreg_q, shreg_d;
  logic                rx_prev_q;
  logic                fall;

  assign fall = rx_prev_q && !rx_sync;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    bits_d    = bits_q;
    shreg_d   = shreg_q;
    byte_done = 1'b0;
    unique case (state_q)
      RX_IDLE: begin
        cnt_d = '0;
        if (fall) begin
          state_d = RX_START;
        end
      end
      RX_START: begin
        if (cnt_q == HalfLast) begin
          cnt_d   = '0;
          bits_d  = '0;
          state_d = rx_sync ? RX_IDLE : RX_DATA;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      RX_DATA: begin
        if (cnt_q == FullLast) begin
          cnt_d   = '0;
          shreg_d = {rx_sync, shreg_q[DataBits-1:1]};
          bits_d  = bits_q + 1'b1;
          if (bits_q == BitLast) begin
            state_d = RX_STOP;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      RX_STOP: begin
        if (fall) begin
          byte_done = 1'b1;
          cnt_d     = '0;
          state_d   = RX_START;
        end else if (cnt_q == FullLast) begin
          byte_done = rx_sync;
          cnt_d     = '0;
          state_d   = RX_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        state_d = RX_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= RX_IDLE;
      cnt_q     <= '0;
      bits_q    <= '0;
      shreg_q   <= '0;
      rx_prev_q <= 1'b1;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      bits_q    <= bits_d;
      shreg_q   <= shreg_d;
      rx_prev_q <= rx_sync;
    end
  end

  assign byte_out = shreg_q;

endmodule

// File: rtl/srx_port.sv
// Receiver top: synchronisers, framer, holding register and read port.
module srx_port
  import srx_pkg::*;
#(
  parameter int unsigned ClksPerBit = 174,
  parameter int unsigned SyncStages = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_line,
  input  logic              rd_en,
  input  logic              rd_sel,
  input  logic [1:0]        rd_kind,
  output logic [WORD_W-1:0] rd_data
);

  localparam int unsigned HalfW = 2 * DATA_W;

  logic              rst_core_n;
  logic              rx_sync;
  logic              byte_done;
  logic [DATA_W-1:0] byte_new;
  logic [DATA_W-1:0] hold_q, hold_d;
  logic              valid_q, valid_d;
  logic              ovr_q, ovr_d;
  logic              rd_data_hit, rd_stat_hit;
  logic [HalfW-1:0]  half_val;
  logic [DATA_W-1:0] low_byte;

  srx_sync #(.Stages(2), .ResetVal(1'b0)) u_rst_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_in (1'b1),
    .d_out(rst_core_n)
  );

  srx_sync #(.Stages(SyncStages), .ResetVal(1'b1)) u_rx_sync (
    .clk  (clk),
    .rst_n(rst_core_n),
    .d_in (rx_line),
    .d_out(rx_sync)
  );

  srx_framer #(.ClksPerBit(ClksPerBit), .DataBits(DATA_W)) u_framer (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .rx_sync  (rx_sync),
    .byte_done(byte_done),
    .byte_out (byte_new)
  );

  assign rd_data_hit = rd_en && (rd_sel == SEL_DATA);
  assign rd_stat_hit = rd_en && (rd_sel == SEL_STATUS);

  always_comb begin
    hold_d  = hold_q;
    valid_d = valid_q;
    ovr_d   = ovr_q;
    if (byte_done) begin
      hold_d  = byte_new;
      valid_d = 1'b1;
    end else if (rd_data_hit) begin
      valid_d = 1'b0;
    end
    if (byte_done && valid_q && !rd_data_hit) begin
      ovr_d = 1'b1;
    end else if (rd_stat_hit) begin
      ovr_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      hold_q  <= '0;
      valid_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      hold_q  <= hold_d;
      valid_q <= valid_d;
      ovr_q   <= ovr_d;
    end
  end

  assign half_val = valid_q ? {{DATA_W{1'b0}}, hold_q} : {HalfW{1'b1}};
  assign low_byte = half_val[DATA_W-1:0];

  always_comb begin
    if (rd_sel == SEL_STATUS) begin
      rd_data = {{(WORD_W - 2){1'b0}}, ovr_q, valid_q};
    end else if (rd_kind == KIND_BYTE_U) begin
      rd_data = {{(WORD_W - DATA_W){1'b0}}, low_byte};
    end else if (rd_kind == KIND_BYTE_S) begin
      rd_data = {{(WORD_W - DATA_W){low_byte[DATA_W-1]}}, low_byte};
    end else begin
      rd_data = {{(WORD_W - HalfW){half_val[HalfW-1]}}, half_val};
    end
  end

endmodule

// File: rtl/srx_checker.sv
module srx_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_en,
  input logic        rd_sel,
  input logic [1:0]  rd_kind,
  input logic [31:0] rd_data,
  input logic        byte_done,
  input logic        valid_q,
  input logic        ovr_q
);

  AST_DONE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> valid_q); // R1

  AST_EMPTY_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_q && !rd_sel && rd_kind[1]) |-> (rd_data == 32'hFFFF_FFFF)); // R2

  AST_DATA_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_sel && !byte_done) |=> !valid_q); // R4

  AST_STATUS_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_sel && !(byte_done && valid_q)) |=> !ovr_q); // R5

  AST_OVERRUN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && valid_q && !(rd_en && !rd_sel)) |=> ovr_q); // R6

endmodule

bind srx_port srx_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_en    (rd_en),
  .rd_sel   (rd_sel),
  .rd_kind  (rd_kind),
  .rd_data  (rd_data),
  .byte_done(byte_done),
  .valid_q  (valid_q),
  .ovr_q    (ovr_q)
);

// File: tb/sim_srx_port.sv
`timescale 1ns / 1ps
module sim_srx_port;

  localparam int CPB = 8;

  logic        clk;
  logic        rst_n;
  logic        rx_line;
  logic        rd_en;
  logic        rd_sel;
  logic [1:0]  rd_kind;
  logic [31:0] rd_data;

  int errors;
  int checks;
  bit finished;

  srx_port #(.ClksPerBit(CPB), .SyncStages(2)) u0 (
    .clk    (clk),
    .rst_n  (rst_n),
    .rx_line(rx_line),
    .rd_en  (rd_en),
    .rd_sel (rd_sel),
    .rd_kind(rd_kind),
    .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] b, input int stop_len);
    @(negedge clk);
    rx_line = 1'b0;
    idle(CPB);
    for (int i = 0; i < 8; i++) begin
      rx_line = b[i];
      idle(CPB);
    end
    rx_line = 1'b1;
    idle(stop_len);
  endtask

  task automatic do_read(input logic sel, input logic [1:0] kind, output logic [31:0] val);
    @(negedge clk);
    rd_en   = 1'b1;
    rd_sel  = sel;
    rd_kind = kind;
    #1 val = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=0x%08h expected=0x%08h", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    logic [31:0] v;
    logic [31:0] exp;
    errors   = 0;
    checks   = 0;
    finished = 1'b0;
    rx_line  = 1'b1;
    rd_en    = 1'b0;
    rd_sel   = 1'b0;
    rd_kind  = 2'd2;
    rst_n    = 1'b0;
    idle(4);
    rst_n = 1'b1;
    idle(6);

    // R10 reset state, R2 and R3 empty reads
    do_read(1'b1, 2'd0, v); chk("R10 status after reset", v, 32'h0);
    do_read(1'b0, 2'd2, v); chk("R2 empty halfword", v, 32'hFFFF_FFFF);
    do_read(1'b0, 2'd0, v); chk("R3 empty unsigned byte", v, 32'h0000_00FF);
    do_read(1'b0, 2'd1, v); chk("R3 empty signed byte", v, 32'hFFFF_FFFF);

    // R1 R2 R3 R4 sweep over all byte values
    for (int b = 0; b < 256; b++) begin
      send_frame(b[7:0], CPB);
      idle(CPB);
      do_read(1'b1, 2'd0, v); chk("R1 R5 status valid", v, 32'h1);
      case (b % 3)
        0: begin
          exp = {24'h0, b[7:0]};
          do_read(1'b0, 2'd2, v); chk("R2 halfword data", v, exp);
        end
        1: begin
          exp = {24'h0, b[7:0]};
          do_read(1'b0, 2'd0, v); chk("R3 unsigned byte", v, exp);
        end
        default: begin
          exp = {{24{b[7]}}, b[7:0]};
          do_read(1'b0, 2'd1, v); chk("R3 signed byte", v, exp);
        end
      endcase
      do_read(1'b0, 2'd2, v); chk("R4 data read cleared valid", v, 32'hFFFF_FFFF);
    end

    // R7 short start glitch
    @(negedge clk);
    rx_line = 1'b0;
    idle(2);
    rx_line = 1'b1;
    idle(12 * CPB);
    do_read(1'b1, 2'd0, v); chk("R7 glitch rejected", v, 32'h0);

    // R8 zero byte with a low stop bit
    @(negedge clk);
    rx_line = 1'b0;
    idle(10 * CPB);
    rx_line = 1'b1;
    idle(3 * CPB);
    do_read(1'b1, 2'd0, v); chk("R8 framing error discarded", v, 32'h0);

    // R6 overrun, R5 status clears overrun
    send_frame(8'h3C, CPB);
    idle(CPB);
    send_frame(8'hA7, CPB);
    idle(CPB);
    do_read(1'b1, 2'd0, v); chk("R6 overrun set", v, 32'h3);
    do_read(1'b1, 2'd0, v); chk("R5 status read cleared overrun", v, 32'h1);
    do_read(1'b0, 2'd2, v); chk("R6 newest byte kept", v, 32'h0000_00A7);
    do_read(1'b1, 2'd0, v); chk("R4 R5 all clear", v, 32'h0);

    // R9 shortened stop bit followed at once by the next frame
    fork
      begin
        send_frame(8'h5A, 3);
        send_frame(8'hC3, CPB);
      end
      begin
        idle(12 * CPB + 4);
        do_read(1'b0, 2'd2, v); chk("R9 first byte after early start", v, 32'h0000_005A);
      end
    join
    idle(CPB);
    do_read(1'b1, 2'd0, v); chk("R9 second byte valid no overrun", v, 32'h1);
    do_read(1'b0, 2'd2, v); chk("R9 second byte", v, 32'h0000_00C3);

    // R10 reset in the middle of held data
    send_frame(8'h11, CPB);
    idle(CPB);
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(6);
    do_read(1'b0, 2'd2, v); chk("R10 reset empties holding register", v, 32'hFFFF_FFFF);

    finish_run();
  end

endmodule